// File: doc/BRIEF.md
# Two-Step Switching Trajectory Enumerator

This block sits at the front of a predictive balancing controller for a five-level, eight-state-per-phase converter leg. It is given the three-phase state commanded in the previous control cycle, three 3-bit phase states. On a start pulse it sends out every candidate switching trajectory over the next two sampling steps, k+1 and k+2, one trajectory per clock. Each phase switches at most once over the two steps. The later pipeline stages check each trajectory for feasibility, predict the capacitor voltages and select one. Those stages are not part of this block.

The candidate next states of each phase come from a small reachable-state table with four slots per state. Slot 0 is always the present state itself. Two rows are fixed by the converter topology. The other rows can be written through a simple write port while the enumerator is idle.

The trajectories are grouped by the timing pattern of which phases switch at k+1 and which at k+2. The groups are padded so that every run is exactly 343 trajectories long, whatever the starting state. The downstream pipeline therefore sees the same count and the same latency in every control cycle.

Top module: `traj_enum`

## Requirements
- R1: After reset `traj_valid`, `traj_first`, `traj_last` and `done` are low.
- R2: A `start` pulse accepted while idle captures `prev_abc`. Trajectory index 0 appears in the cycle after the capturing edge. Indices 0 to 342 follow on consecutive cycles with `traj_valid` high, and `traj_valid` is low otherwise.
- R3: Trajectories come in eight timing groups, each identified by a mask of the phases that switch at k+1 (bit 0 = a, bit 1 = b, bit 2 = c). The groups appear in this order: 111, 001, 010, 100, 011, 101, 110, 000. A phase draws from slots 0..3 if it switches at k+1 in group 111, or if it switches at k+2 in a mixed group. In every other case it draws from slots 1..3. Within a group the slot of phase a changes fastest, then b, then c, each counting upward.
- R4: A phase that switches at k+2 shows its present state at k+1. For every phase, the k+2 state is the table entry for its present state and chosen slot. Slot 0 returns the present state.
- R5: The row for state 3 holds 1, 2, 5 in slots 1, 2, 3. The row for state 7 holds 5, 6, 7 in slots 1, 2, 3.
- R6: After reset, programmable row s holds (s+j) mod 8 in slot j. A write with `tbl_we` high stores `tbl_data` at (`tbl_state`, `tbl_slot`), and the next run uses the new value.
- R7: Writes to slot 0, or to the rows of states 3 and 7, leave the table unchanged.
- R8: Writes issued while trajectories are being emitted leave the table unchanged.
- R9: A `start` pulse during a run neither restarts nor alters that run.
- R10: `traj_first` marks index 0 and `traj_last` marks index 342 and no other index. `done` is high for exactly the one cycle after the cycle of index 342.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin enumeration from `prev_abc` |
| prev_abc | input | 9 | Previous phase states {c,b,a}, 3 bits each |
| tbl_we | input | 1 | Table write enable |
| tbl_state | input | 3 | Row (present state) to write |
| tbl_slot | input | 2 | Slot to write (1..3) |
| tbl_data | input | 3 | Next-state value to store |
| traj_valid | output | 1 | A trajectory is on the outputs |
| traj_first | output | 1 | Trajectory index 0 |
| traj_last | output | 1 | Trajectory index 342 |
| step1_abc | output | 9 | States {c,b,a} at k+1 |
| step2_abc | output | 9 | States {c,b,a} at k+2 |
| done | output | 1 | One-cycle pulse after the last trajectory |

## Verification
The bench targets the boundaries where the slot range of a phase changes. Between the all-at-k+1 group and the mixed groups, the slot range flips from 0..3 to 1..3. A design that gets this flip wrong either emits a do-nothing trajectory twice or misses one, which shifts every later index and moves `traj_last`. Runs start from the fixed rows, from programmed rows and from illegal write targets. A table that accepted a write to a fixed row, to slot 0 or during a run would show a changed k+2 state in the next run. A start pulse in the middle of a run is also applied; a sequencer that restarted on it would emit index 0 again and never reach `done` on time.

// File: rtl/traj_enum_pkg.sv
package traj_enum_pkg;

   localparam int PH   = 3;
   localparam int NGRP = 8;

   // timing-group order: mask of phases switching at k+1 (bit0 = phase a)
   function automatic logic [PH-1:0] grp_mask(input logic [2:0] g);
      case (g)
         3'd0:    return 3'b111;
         3'd1:    return 3'b001;
         3'd2:    return 3'b010;
         3'd3:    return 3'b100;
         3'd4:    return 3'b011;
         3'd5:    return 3'b101;
         3'd6:    return 3'b110;
         default: return 3'b000;
      endcase
   endfunction

   // 1: phase p may also keep its present state (slot 0 allowed)
   function automatic logic slot_full(input logic [PH-1:0] m, input int p);
      if (m == '1) return 1'b1;
      if (m == '0) return 1'b0;
      return ~m[p];
   endfunction

endpackage

// File: rtl/traj_enum_table.sv
module traj_enum_table #(
   parameter int ST_W  = 3,
   parameter int SLOTS = 4,
   parameter int NRD   = 3,
   parameter int FIX_A_STATE = 3,
   parameter logic [(SLOTS-1)*ST_W-1:0] FIX_A_ROW = {3'd5, 3'd2, 3'd1},
   parameter int FIX_B_STATE = 7,
   parameter logic [(SLOTS-1)*ST_W-1:0] FIX_B_ROW = {3'd7, 3'd6, 3'd5},
   localparam int SW  = $clog2(SLOTS),
   localparam int NST = 1 << ST_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock,
   input  logic                we,
   input  logic [ST_W-1:0]     wr_state,
   input  logic [SW-1:0]       wr_slot,
   input  logic [ST_W-1:0]     wr_data,
   input  logic [NRD*ST_W-1:0] rd_state,
   input  logic [NRD*SW-1:0]   rd_slot,
   output logic [NRD*ST_W-1:0] rd_data
);

   // row[s][j-1] holds slot j of state s; slot 0 is implicit
   logic [ST_W-1:0] row [NST][SLOTS-1];

   for (genvar s = 0; s < NST; s++) begin : g_st
      for (genvar j = 1; j < SLOTS; j++) begin : g_sl
         if (s == FIX_A_STATE) begin : g_fa
            assign row[s][j-1] = FIX_A_ROW[(j-1)*ST_W +: ST_W];
         end else if (s == FIX_B_STATE) begin : g_fb
            assign row[s][j-1] = FIX_B_ROW[(j-1)*ST_W +: ST_W];
         end else begin : g_rw
            logic [ST_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= ST_W'((s + j) % NST);
               else if (we && !lock && wr_state == ST_W'(s) && wr_slot == SW'(j))
                  q <= wr_data;
            end
            assign row[s][j-1] = q;
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [ST_W-1:0] st;
      logic [SW-1:0]   sl;
      assign st = rd_state[r*ST_W +: ST_W];
      assign sl = rd_slot[r*SW +: SW];
      assign rd_data[r*ST_W +: ST_W] = (sl == '0) ? st : row[st][sl - 1'b1];
   end

endmodule

// File: rtl/traj_enum_seq.sv
module traj_enum_seq
   import traj_enum_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int DW = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [2:0]       grp,
   output logic [PH*DW-1:0] dig,
   output logic             first,
   output logic             last,
   output logic             done
);

   logic [PH-1:0]    mask;
   logic [PH*DW-1:0] dig_nx;
   logic             wrap;

   assign mask = grp_mask(grp);

   // mixed-radix increment, phase a fastest
   always_comb begin
      logic          c;
      logic [DW-1:0] mx;
      c      = 1'b1;
      dig_nx = dig;
      for (int p = 0; p < PH; p++) begin
         mx = slot_full(mask, p) ? DW'(SLOTS - 1) : DW'(SLOTS - 2);
         if (c) begin
            if (dig[p*DW +: DW] == mx) begin
               dig_nx[p*DW +: DW] = '0;
            end else begin
               dig_nx[p*DW +: DW] = dig[p*DW +: DW] + 1'b1;
               c = 1'b0;
            end
         end
      end
      wrap = c;
   end

   assign first = busy && (grp == '0) && (dig == '0);
   assign last  = busy && (grp == 3'(NGRP - 1)) && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         grp  <= '0;
         dig  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               grp  <= '0;
               dig  <= '0;
            end
         end else begin
            dig <= dig_nx;
            if (wrap) begin
               if (grp == 3'(NGRP - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  grp <= grp + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/traj_enum.sv
module traj_enum
   import traj_enum_pkg::*;
#(
   parameter int ST_W  = 3,
   parameter int SLOTS = 4,
   parameter int FIX_A_STATE = 3,
   parameter logic [(SLOTS-1)*ST_W-1:0] FIX_A_ROW = {3'd5, 3'd2, 3'd1},
   parameter int FIX_B_STATE = 7,
   parameter logic [(SLOTS-1)*ST_W-1:0] FIX_B_ROW = {3'd7, 3'd6, 3'd5},
   localparam int SW = $clog2(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PH*ST_W-1:0] prev_abc,
   input  logic               tbl_we,
   input  logic [ST_W-1:0]    tbl_state,
   input  logic [SW-1:0]      tbl_slot,
   input  logic [ST_W-1:0]    tbl_data,
   output logic               traj_valid,
   output logic               traj_first,
   output logic               traj_last,
   output logic [PH*ST_W-1:0] step1_abc,
   output logic [PH*ST_W-1:0] step2_abc,
   output logic               done
);

   if (SLOTS < 2 || SLOTS > (1 << ST_W)) begin : g_bad_slots
      $error("traj_enum: SLOTS must lie in 2..2**ST_W");
   end
   if (FIX_A_STATE == FIX_B_STATE) begin : g_bad_fix
      $error("traj_enum: fixed rows must be distinct states");
   end

   logic               busy;
   logic [2:0]         grp;
   logic [PH*SW-1:0]   dig;
   logic [PH-1:0]      mask;
   logic [PH*ST_W-1:0] ps;
   logic [PH*SW-1:0]   rd_slot;
   logic [PH*ST_W-1:0] nxt;
   logic [PH*ST_W-1:0] s1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ps <= '0;
      else if (start && !busy)
         ps <= prev_abc;
   end

   traj_enum_seq #(.SLOTS(SLOTS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .grp   (grp),
      .dig   (dig),
      .first (traj_first),
      .last  (traj_last),
      .done  (done)
   );

   assign mask = grp_mask(grp);

   for (genvar p = 0; p < PH; p++) begin : g_ph
      assign rd_slot[p*SW +: SW] = dig[p*SW +: SW] + (slot_full(mask, p) ? SW'(0) : SW'(1));
      assign s1[p*ST_W +: ST_W]  = mask[p] ? nxt[p*ST_W +: ST_W] : ps[p*ST_W +: ST_W];
   end

   traj_enum_table #(
      .ST_W(ST_W), .SLOTS(SLOTS), .NRD(PH),
      .FIX_A_STATE(FIX_A_STATE), .FIX_A_ROW(FIX_A_ROW),
      .FIX_B_STATE(FIX_B_STATE), .FIX_B_ROW(FIX_B_ROW)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (busy),
      .we       (tbl_we),
      .wr_state (tbl_state),
      .wr_slot  (tbl_slot),
      .wr_data  (tbl_data),
      .rd_state (ps),
      .rd_slot  (rd_slot),
      .rd_data  (nxt)
   );

   assign traj_valid = busy;
   assign step1_abc  = busy ? s1  : '0;
   assign step2_abc  = busy ? nxt : '0;

endmodule

// File: rtl/traj_enum_chk.sv
module traj_enum_chk #(
   parameter int SLOTS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic traj_valid,
   input logic traj_first,
   input logic traj_last,
   input logic done
);

   localparam int TOTAL = (2*SLOTS - 1) ** 3;
   localparam int CW    = $clog2(TOTAL + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (traj_first) cnt <= CW'(1);
      else if (traj_valid) cnt <= cnt + 1'b1;
   end

   // R2
   first_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      traj_first |-> traj_valid);

   // R10
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      traj_last |-> (cnt == CW'(TOTAL - 1)));

   // R10
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      traj_last |=> (done && !traj_valid));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (traj_valid && !traj_last) |=> (traj_valid && !traj_first));

   // R3
   first_last_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      traj_first |-> !traj_last);

endmodule

bind traj_enum traj_enum_chk #(.SLOTS(SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .traj_valid (traj_valid),
   .traj_first (traj_first),
   .traj_last  (traj_last),
   .done       (done)
);

// File: tb/sim_traj_enum.sv
module sim_traj_enum;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [8:0] prev_abc = '0;
   logic       tbl_we = 1'b0;
   logic [2:0] tbl_state = '0;
   logic [1:0] tbl_slot = '0;
   logic [2:0] tbl_data = '0;
   logic       traj_valid, traj_first, traj_last, done;
   logic [8:0] step1_abc, step2_abc;

   int  nvec = 0;
   int  nmis = 0;
   bit  ended = 1'b0;
   logic [2:0] mdl [8][4];

   always #2 clk = ~clk;

   traj_enum u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .prev_abc(prev_abc),
      .tbl_we(tbl_we), .tbl_state(tbl_state), .tbl_slot(tbl_slot), .tbl_data(tbl_data),
      .traj_valid(traj_valid), .traj_first(traj_first), .traj_last(traj_last),
      .step1_abc(step1_abc), .step2_abc(step2_abc), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nmis++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] bmask(input int g);
      case (g)
         0: return 3'b111; 1: return 3'b001; 2: return 3'b010; 3: return 3'b100;
         4: return 3'b011; 5: return 3'b101; 6: return 3'b110; default: return 3'b000;
      endcase
   endfunction

   task automatic wr(input int st, input int sl, input int d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_state = 3'(st); tbl_slot = 2'(sl); tbl_data = 3'(d);
      @(negedge clk);
      tbl_we = 1'b0;
      // R6 / R7: only programmable rows and slots 1..3 take the write
      if (sl != 0 && st != 3 && st != 7) mdl[st][sl] = 3'(d);
   endtask

   task automatic run(input int pa, input int pb, input int pc, input string tag, input bit disturb);
      int pv[3];
      int lo[3];
      int idx;
      logic [2:0] m;
      logic [8:0] e1, e2;
      pv[0] = pa; pv[1] = pb; pv[2] = pc;
      @(negedge clk);
      prev_abc = {3'(pc), 3'(pb), 3'(pa)};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev_abc = '0;
      idx = 0;
      for (int g = 0; g < 8; g++) begin
         m = bmask(g);
         for (int p = 0; p < 3; p++)
            lo[p] = ((m == 3'b111) || (m != 3'b000 && !m[p])) ? 0 : 1;
         for (int ic = lo[2]; ic < 4; ic++)
            for (int ib = lo[1]; ib < 4; ib++)
               for (int ia = lo[0]; ia < 4; ia++) begin
                  int sel[3];
                  sel[0] = ia; sel[1] = ib; sel[2] = ic;
                  for (int p = 0; p < 3; p++) begin
                     e2[p*3 +: 3] = mdl[pv[p]][sel[p]];
                     e1[p*3 +: 3] = m[p] ? mdl[pv[p]][sel[p]] : 3'(pv[p]);
                  end
                  chk(traj_valid == 1'b1, "R2 valid", 32'(traj_valid), 1);
                  chk(traj_first == (idx == 0), "R10 first", 32'(traj_first), 32'(idx == 0));
                  chk(traj_last == (idx == 342), "R10 last", 32'(traj_last), 32'(idx == 342));
                  chk(step1_abc == e1, {tag, " step1"}, 32'(step1_abc), 32'(e1));
                  chk(step2_abc == e2, {tag, " step2"}, 32'(step2_abc), 32'(e2));
                  for (int p = 0; p < 3; p++)
                     if (!m[p])
                        chk(step1_abc[p*3 +: 3] == 3'(pv[p]), "R4 hold", 32'(step1_abc[p*3 +: 3]), 32'(pv[p]));
                  if (disturb) begin
                     // R8: write while busy; R9: start while busy
                     if (idx == 100) begin tbl_we = 1'b1; tbl_state = 3'd2; tbl_slot = 2'd1; tbl_data = 3'd0; end
                     if (idx == 101) tbl_we = 1'b0;
                     if (idx == 150) begin start = 1'b1; prev_abc = 9'h1ff; end
                     if (idx == 151) begin start = 1'b0; prev_abc = '0; end
                  end
                  idx++;
                  @(negedge clk);
               end
      end
      chk(done == 1'b1 && traj_valid == 1'b0, "R10 done", {30'd0, done, traj_valid}, 32'h2);
      @(negedge clk);
      chk(done == 1'b0, "R10 done pulse", 32'(done), 0);
   endtask

   initial begin
      for (int s = 0; s < 8; s++) begin
         mdl[s][0] = 3'(s);
         for (int j = 1; j < 4; j++) mdl[s][j] = 3'((s + j) % 8);
      end
      mdl[3][1] = 3'd1; mdl[3][2] = 3'd2; mdl[3][3] = 3'd5;
      mdl[7][1] = 3'd5; mdl[7][2] = 3'd6; mdl[7][3] = 3'd7;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(traj_valid == 1'b0, "R1 valid", 32'(traj_valid), 0);
      chk(traj_first == 1'b0, "R1 first", 32'(traj_first), 0);
      chk(traj_last == 1'b0, "R1 last", 32'(traj_last), 0);
      chk(done == 1'b0, "R1 done", 32'(done), 0);

      run(0, 0, 0, "R3", 0);
      run(3, 3, 3, "R5", 0);
      run(7, 7, 7, "R5", 0);
      run(7, 3, 5, "R5", 0);
      run(1, 2, 4, "R3", 0);
      for (int t = 0; t < 12; t++)
         run(t % 8, (3*t + 1) % 8, (5*t + 2) % 8, "R3", 0);

      // R6: programmed rows
      wr(0, 2, 6);
      wr(5, 1, 0);
      wr(6, 3, 3);
      run(0, 5, 6, "R6", 0);

      // R7: fixed rows and slot 0 are not writable
      wr(3, 1, 7);
      wr(7, 3, 0);
      wr(1, 0, 4);
      run(3, 7, 1, "R7", 0);

      // R9 during the run, R8 seen in the following run
      run(2, 4, 2, "R9", 1);
      run(2, 2, 2, "R8", 0);

      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!ended) begin
         ended = 1'b1;
         nmis++;
         $display("FAIL R2 watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
         $finish;
      end
   end

endmodule